// File: doc/BRIEF.md
# Time and Alarm Register Window with Write Lock

This block holds the time-of-day, calendar and alarm fields of a real-time clock and presents them to a 16-bit host bus. It does not give each field its own address. Two data windows each show one pair of fields at a time. A 2-bit pointer per window selects the pair, and the pointer steps down by one on each access. Software can therefore set the pointer once and then sweep through the fields with back-to-back accesses to a single address.

A configuration register holds the module enable, the write-enable bit, the time-window pointer and an 8-bit calibration value. An alarm configuration register holds the alarm-window pointer and the remaining alarm control bits as plain storage. The time fields and the module enable can only be written while the write-enable bit is set. That bit can only be raised in the single cycle that directly follows a two-byte key sequence written to a key register. The counting and alarm-matching datapaths are separate blocks. They read the stored fields through the slot outputs.

The bus has a 3-bit address: 0 = configuration, 1 = alarm configuration, 2 = time window, 3 = alarm window, 4 = key. Reads are combinational while the read strobe is high, and the output is zero otherwise. Writes take effect on the clock edge that ends the strobe cycle.

Top module: `rtc_regwin`

## Requirements
- R1: After power-on reset, the configuration register, the alarm configuration register and both windows read 0x0000.
- R2: Configuration register layout: bit 15 = enable, bit 13 = write-enable, bits 9:8 = time pointer, bits 7:0 = calibration, all other bits read 0. Time window pairs, given as upper byte / lower byte: pointer 0 = minutes (bits 14:8) / seconds (bits 6:0); pointer 1 = weekday (bits 10:8) / hours (bits 5:0); pointer 2 = month (bits 12:8) / day (bits 5:0); pointer 3 = nothing / year (bits 7:0). Unimplemented bits read 0.
- R3: The alarm window uses the same pairs for pointers 0 to 2. Pointer 3 reads 0x0000 and stores nothing. Alarm configuration: bits 9:8 = alarm pointer, bits 15:10 and 7:0 = stored control bits. Alarm writes do not depend on the write-enable bit.
- R4: A read of a window, whatever its byte enables, decrements that window's pointer by one, stopping at 0, and leaves the fields unchanged.
- R5: A window write updates only the bytes whose byte enable is set. It decrements the pointer (stopping at 0) only when byte enable 1 (upper byte) is set.
- R6: While write-enable is 0, a time-window write has no effect on the fields or the pointer, and a configuration write leaves the enable bit unchanged.
- R7: Write-enable becomes 1 only through a configuration write with bit 13 set, in the cycle right after the writes 0x55 and then 0xAA to the low byte of the key register. Any other write in between, or any idle or read cycle before the configuration write, cancels the sequence.
- R8: A configuration write with bit 13 clear always clears write-enable.
- R9: Writing a pointer field through its configuration register loads that value exactly, and this write does not decrement the pointer.
- R10: The general reset clears the alarm configuration, including the alarm pointer. It leaves the configuration register and all field contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| rst_n_i | input | 1 | General reset, asynchronous, active low |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| be_i | input | 2 | Byte enables, bit 1 = upper byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero when rd_i is low |
| en_o | output | 1 | Module enable to the counter datapath |
| cal_o | output | 8 | Calibration value |
| acfg_o | output | 16 | Alarm configuration image |
| time_slots_o | output | 64 | Time fields, four 16-bit slots indexed by pointer code |
| alarm_slots_o | output | 64 | Alarm fields, four 16-bit slots indexed by pointer code |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that each strobe marks exactly one access per cycle, because a strobe held for two cycles counts as two accesses and would move a pointer twice. The bench drives every access as a single-cycle pulse with only one strobe active. It places key-sequence cycles back to back whenever the unlock has to succeed, and it inserts a read cycle or a foreign key byte whenever the unlock has to fail. Expected read data follows from the pointer walk described by R4, R5 and R9, applied to the field masks of R2 and R3.

// File: rtl/rtc_regwin_pkg.sv
package rtc_regwin_pkg;

  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;
  localparam int PTR_W   = 2;
  localparam int BYTES_W = DATA_W / 8;

  localparam logic [ADDR_W-1:0] ADR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ACFG = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_TWIN = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_AWIN = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_KEY  = 3'd4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int CFG_EN_BIT   = 15;
  localparam int CFG_WREN_BIT = 13;
  localparam int CFG_PTR_LSB  = 8;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } key_state_e;

  // Implemented bits of each field pair, indexed by pointer code.
  function automatic logic [DATA_W-1:0] slot_mask(input bit has_year, input int idx);
    logic [DATA_W-1:0] m;
    case (idx)
      0:       m = 16'h7F7F;
      1:       m = 16'h073F;
      2:       m = 16'h1F3F;
      default: m = has_year ? 16'h00FF : 16'h0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rtc_regwin_key.sv
module rtc_regwin_key
  import rtc_regwin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       wr_i,
  input  logic       key_hit_i,
  input  logic       lo_en_i,
  input  logic [7:0] data_i,
  output logic       armed_o
);

  key_state_e state_q, state_d;
  logic       key_wr;

  assign key_wr = wr_i & key_hit_i & lo_en_i;

  always_comb begin
    state_d = state_q;
    if (wr_i) begin
      if (key_wr && data_i == KEY_FIRST)
        state_d = KEY_HALF;
      else if (key_wr && data_i == KEY_SECOND && state_q == KEY_HALF)
        state_d = KEY_ARMED;
      else
        state_d = KEY_IDLE;
    end else if (state_q == KEY_ARMED) begin
      state_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= KEY_IDLE;
    else          state_q <= state_d;
  end

  assign armed_o = (state_q == KEY_ARMED);

  // R7: the unlock window is a single cycle
  a_r7_armed_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    armed_o |=> !armed_o);

  // R7: arming needs the first key byte in the cycle before
  a_r7_armed_after_half: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(armed_o) |-> $past(state_q == KEY_HALF));

endmodule

// File: rtl/rtc_regwin_window.sv
module rtc_regwin_window
  import rtc_regwin_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PW       = 2,
  parameter bit HAS_YEAR = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     fld_rst_n_i,
  input  logic                     ptr_rst_n_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [DW/8-1:0]          be_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     wr_allow_i,
  input  logic                     ptr_ld_i,
  input  logic [PW-1:0]            ptr_ld_val_i,
  output logic [PW-1:0]            ptr_o,
  output logic [DW-1:0]            rdata_o,
  output logic [(1<<PW)*DW-1:0]    slots_o
);

  localparam int NSLOT = 1 << PW;
  localparam int NBYTE = DW / 8;

  logic [PW-1:0]              ptr_q, ptr_d;
  logic [NSLOT-1:0][DW-1:0]   slot_q, slot_d;
  logic [DW-1:0]              bmask;
  logic                       wr_ok, step;

  assign wr_ok = wr_i & wr_allow_i;
  assign step  = rd_i | (wr_ok & be_i[NBYTE-1]);

  for (genvar b = 0; b < NBYTE; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{be_i[b]}};
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_ld_i)
      ptr_d = ptr_ld_val_i;
    else if (step && ptr_q != '0)
      ptr_d = ptr_q - 1'b1;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [DW-1:0] IMPL = DW'(slot_mask(HAS_YEAR, s));
    logic hit;
    assign hit       = wr_ok & (ptr_q == PW'(s));
    assign slot_d[s] = hit ? (((slot_q[s] & ~bmask) | (wdata_i & bmask)) & IMPL)
                           : slot_q[s];
  end

  always_ff @(posedge clk_i or negedge ptr_rst_n_i) begin
    if (!ptr_rst_n_i) ptr_q <= '0;
    else              ptr_q <= ptr_d;
  end

  always_ff @(posedge clk_i or negedge fld_rst_n_i) begin
    if (!fld_rst_n_i) slot_q <= '0;
    else              slot_q <= slot_d;
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = slot_q[ptr_q];
  assign slots_o = slot_q;

  // R4: reads never change field contents
  a_r4_read_keeps_fields: assert property (@(posedge clk_i)
    disable iff (!fld_rst_n_i || !ptr_rst_n_i)
    rd_i |=> $stable(slot_q));

  // R4: the pointer stops at zero
  a_r4_ptr_floor: assert property (@(posedge clk_i)
    disable iff (!fld_rst_n_i || !ptr_rst_n_i)
    (rd_i && ptr_q == '0 && !ptr_ld_i) |=> ptr_q == '0);

  // R5: a write without the upper byte keeps the pointer
  a_r5_lower_write_no_step: assert property (@(posedge clk_i)
    disable iff (!fld_rst_n_i || !ptr_rst_n_i)
    (wr_i && !be_i[NBYTE-1] && !ptr_ld_i) |=> $stable(ptr_q));

  // R6: a locked write touches neither fields nor pointer
  a_r6_locked_write_inert: assert property (@(posedge clk_i)
    disable iff (!fld_rst_n_i || !ptr_rst_n_i)
    (wr_i && !wr_allow_i && !ptr_ld_i) |=> ($stable(slot_q) && $stable(ptr_q)));

endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
  import rtc_regwin_pkg::*;
(
  input  logic                clk_i,
  input  logic                por_n_i,
  input  logic                rst_n_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [BYTES_W-1:0]  be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                en_o,
  output logic [7:0]          cal_o,
  output logic [DATA_W-1:0]   acfg_o,
  output logic [4*DATA_W-1:0] time_slots_o,
  output logic [4*DATA_W-1:0] alarm_slots_o
);

  localparam int HI = BYTES_W - 1;

  logic sys_rst_n;
  assign sys_rst_n = por_n_i & rst_n_i;

  logic hit_cfg, hit_acfg, hit_twin, hit_awin, hit_key;
  assign hit_cfg  = (addr_i == ADR_CFG);
  assign hit_acfg = (addr_i == ADR_ACFG);
  assign hit_twin = (addr_i == ADR_TWIN);
  assign hit_awin = (addr_i == ADR_AWIN);
  assign hit_key  = (addr_i == ADR_KEY);

  logic cfg_wr, acfg_wr;
  assign cfg_wr  = wr_i & hit_cfg;
  assign acfg_wr = wr_i & hit_acfg;

  // configuration register state
  logic       en_q, en_d, wren_q, wren_d;
  logic [7:0] cal_q, cal_d;
  logic [5:0] acfg_hi_q, acfg_hi_d;
  logic [7:0] acfg_lo_q, acfg_lo_d;
  logic       armed;

  rtc_regwin_key u_key (
    .clk_i     (clk_i),
    .rst_n_i   (sys_rst_n),
    .wr_i      (wr_i),
    .key_hit_i (hit_key),
    .lo_en_i   (be_i[0]),
    .data_i    (wdata_i[7:0]),
    .armed_o   (armed)
  );

  always_comb begin
    en_d   = en_q;
    wren_d = wren_q;
    cal_d  = cal_q;
    if (cfg_wr && be_i[HI]) begin
      if (wren_q)
        en_d = wdata_i[CFG_EN_BIT];
      if (!wdata_i[CFG_WREN_BIT])
        wren_d = 1'b0;
      else if (armed)
        wren_d = 1'b1;
    end
    if (cfg_wr && be_i[0])
      cal_d = wdata_i[7:0];
  end

  always_comb begin
    acfg_hi_d = acfg_hi_q;
    acfg_lo_d = acfg_lo_q;
    if (acfg_wr && be_i[HI]) acfg_hi_d = wdata_i[15:10];
    if (acfg_wr && be_i[0])  acfg_lo_d = wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      en_q   <= 1'b0;
      wren_q <= 1'b0;
      cal_q  <= '0;
    end else begin
      en_q   <= en_d;
      wren_q <= wren_d;
      cal_q  <= cal_d;
    end
  end

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      acfg_hi_q <= '0;
      acfg_lo_q <= '0;
    end else begin
      acfg_hi_q <= acfg_hi_d;
      acfg_lo_q <= acfg_lo_d;
    end
  end

  // field windows
  logic [PTR_W-1:0]  tptr, aptr;
  logic [DATA_W-1:0] t_rdata, a_rdata;

  rtc_regwin_window #(.DW(DATA_W), .PW(PTR_W), .HAS_YEAR(1'b1)) u_twin (
    .clk_i        (clk_i),
    .fld_rst_n_i  (por_n_i),
    .ptr_rst_n_i  (por_n_i),
    .rd_i         (rd_i & hit_twin),
    .wr_i         (wr_i & hit_twin),
    .be_i         (be_i),
    .wdata_i      (wdata_i),
    .wr_allow_i   (wren_q),
    .ptr_ld_i     (cfg_wr & be_i[HI]),
    .ptr_ld_val_i (wdata_i[CFG_PTR_LSB +: PTR_W]),
    .ptr_o        (tptr),
    .rdata_o      (t_rdata),
    .slots_o      (time_slots_o)
  );

  rtc_regwin_window #(.DW(DATA_W), .PW(PTR_W), .HAS_YEAR(1'b0)) u_awin (
    .clk_i        (clk_i),
    .fld_rst_n_i  (por_n_i),
    .ptr_rst_n_i  (sys_rst_n),
    .rd_i         (rd_i & hit_awin),
    .wr_i         (wr_i & hit_awin),
    .be_i         (be_i),
    .wdata_i      (wdata_i),
    .wr_allow_i   (1'b1),
    .ptr_ld_i     (acfg_wr & be_i[HI]),
    .ptr_ld_val_i (wdata_i[CFG_PTR_LSB +: PTR_W]),
    .ptr_o        (aptr),
    .rdata_o      (a_rdata),
    .slots_o      (alarm_slots_o)
  );

  logic [DATA_W-1:0] cfg_img, acfg_img;
  assign cfg_img  = {en_q, 1'b0, wren_q, 3'b000, tptr, cal_q};
  assign acfg_img = {acfg_hi_q, aptr, acfg_lo_q};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_cfg)       rdata_o = cfg_img;
      else if (hit_acfg) rdata_o = acfg_img;
      else if (hit_twin) rdata_o = t_rdata;
      else if (hit_awin) rdata_o = a_rdata;
    end
  end

  assign en_o   = en_q;
  assign cal_o  = cal_q;
  assign acfg_o = acfg_img;

  // Input assumption: one strobe per cycle
  a_in_single_strobe: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !(rd_i && wr_i));

  // R7: write-enable only rises straight after the key sequence
  a_r7_wren_needs_key: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    $rose(wren_q) |-> $past(armed));

  // R8: clearing write-enable is never refused
  a_r8_wren_clear: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (cfg_wr && be_i[HI] && !wdata_i[CFG_WREN_BIT]) |=> !wren_q);

  // R6: enable bit is frozen while locked
  a_r6_en_locked: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (cfg_wr && !wren_q) |=> $stable(en_q));

endmodule

// File: tb/rtc_regwin_bench.sv
module rtc_regwin_bench;

  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic [2:0]  addr;
  logic        rd, wr;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        en;
  logic [7:0]  cal;
  logic [15:0] acfg;
  logic [63:0] tslots, aslots;

  int n_vec  = 0;
  int n_fail = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam logic [2:0] CFG = 3'd0, ACFG = 3'd1, TWIN = 3'd2, AWIN = 3'd3, KEY = 3'd4;

  always #10 clk = ~clk;

  rtc_regwin u_rtc_regwin (
    .clk_i         (clk),
    .por_n_i       (por_n),
    .rst_n_i       (rst_n),
    .addr_i        (addr),
    .rd_i          (rd),
    .wr_i          (wr),
    .be_i          (be),
    .wdata_i       (wdata),
    .rdata_o       (rdata),
    .en_o          (en),
    .cal_o         (cal),
    .acfg_o        (acfg),
    .time_slots_o  (tslots),
    .alarm_slots_o (aslots)
  );

  task automatic finish_strobe();
    @(posedge clk);
    #2;
    rd = 1'b0;
    wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [1:0] b, input logic [15:0] d);
    addr = a; be = b; wdata = d; wr = 1'b1;
    finish_strobe();
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [1:0] b,
                        input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr = a; be = b; rd = 1'b1;
    finish_strobe();
  endtask

  // Monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (rd && por_n) begin
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: unexpected read, actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0;
    addr = '0; rd = 1'b0; wr = 1'b0; be = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #2;
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    rd_chk(CFG,  2'b11, 16'h0000, "R1 cfg");
    rd_chk(ACFG, 2'b11, 16'h0000, "R1 acfg");
    rd_chk(TWIN, 2'b11, 16'h0000, "R1 time window");
    rd_chk(AWIN, 2'b11, 16'h0000, "R1 alarm window");

    // R6 locked writes
    wr_reg(TWIN, 2'b11, 16'h1234);
    rd_chk(TWIN, 2'b11, 16'h0000, "R6 locked field write");
    wr_reg(CFG,  2'b11, 16'h8000);
    rd_chk(CFG,  2'b11, 16'h0000, "R6 locked enable write");

    // R7 unlock: key bytes then cfg in consecutive cycles
    wr_reg(KEY, 2'b01, 16'h0055);
    wr_reg(KEY, 2'b01, 16'h00AA);
    wr_reg(CFG, 2'b11, 16'h2300);
    rd_chk(CFG, 2'b11, 16'h2300, "R7 unlock sets write-enable");

    // R5 write walk with decrement and floor, R2 masks
    wr_reg(TWIN, 2'b11, 16'hFF99);
    rd_chk(CFG, 2'b11, 16'h2200, "R5 upper write decrements");
    wr_reg(TWIN, 2'b11, 16'hFFFF);
    wr_reg(TWIN, 2'b11, 16'hFFFF);
    wr_reg(TWIN, 2'b11, 16'hFFFF);
    rd_chk(CFG, 2'b11, 16'h2000, "R5 pointer floor on write");

    // R9 direct pointer load
    wr_reg(CFG, 2'b11, 16'h2300);
    rd_chk(CFG, 2'b11, 16'h2300, "R9 pointer load no decrement");

    // R2 / R4 read walk
    rd_chk(TWIN, 2'b11, 16'h0099, "R2 year slot");
    rd_chk(TWIN, 2'b11, 16'h1F3F, "R2 month/day slot");
    rd_chk(TWIN, 2'b11, 16'h073F, "R2 weekday/hours slot");
    rd_chk(TWIN, 2'b11, 16'h7F7F, "R2 minutes/seconds slot");
    rd_chk(TWIN, 2'b11, 16'h7F7F, "R4 read floor at zero");
    rd_chk(CFG,  2'b11, 16'h2000, "R4 pointer after reads");

    // R5 lower-byte-only write
    wr_reg(CFG,  2'b11, 16'h2100);
    wr_reg(TWIN, 2'b01, 16'h0012);
    rd_chk(CFG,  2'b11, 16'h2100, "R5 lower write no decrement");
    rd_chk(TWIN, 2'b11, 16'h0712, "R5 byte enable honoured");

    // R6 enable accepted while unlocked, R8 clear
    wr_reg(CFG, 2'b11, 16'hA000);
    rd_chk(CFG, 2'b11, 16'hA000, "R6 enable written when unlocked");
    wr_reg(CFG, 2'b11, 16'h8000);
    rd_chk(CFG, 2'b11, 16'h8000, "R8 write-enable cleared");

    // R6 locked again
    wr_reg(CFG,  2'b11, 16'h0200);
    rd_chk(CFG,  2'b11, 16'h8200, "R6 enable held while locked");
    wr_reg(TWIN, 2'b11, 16'h0101);
    rd_chk(CFG,  2'b11, 16'h8200, "R6 locked write keeps pointer");
    rd_chk(TWIN, 2'b11, 16'h1F3F, "R6 locked write keeps field");

    // R7 broken sequences
    wr_reg(KEY, 2'b01, 16'h0055);
    wr_reg(KEY, 2'b01, 16'h0012);
    wr_reg(KEY, 2'b01, 16'h00AA);
    wr_reg(CFG, 2'b11, 16'hA200);
    rd_chk(CFG, 2'b11, 16'h8200, "R7 foreign key byte cancels");
    wr_reg(KEY, 2'b01, 16'h0055);
    wr_reg(KEY, 2'b01, 16'h00AA);
    rd_chk(CFG, 2'b11, 16'h8200, "R7 armed read");
    wr_reg(CFG, 2'b11, 16'h2200);
    rd_chk(CFG, 2'b11, 16'h8200, "R7 late cfg write refused");

    // R3 alarm window
    wr_reg(ACFG, 2'b11, 16'hC2A5);
    rd_chk(ACFG, 2'b11, 16'hC2A5, "R3 alarm config image");
    wr_reg(AWIN, 2'b11, 16'h1231);
    wr_reg(AWIN, 2'b11, 16'h0623);
    wr_reg(AWIN, 2'b11, 16'h5959);
    wr_reg(ACFG, 2'b11, 16'hC3A5);
    wr_reg(AWIN, 2'b11, 16'hFFFF);
    rd_chk(ACFG, 2'b11, 16'hC2A5, "R3 code 3 write steps pointer");
    wr_reg(ACFG, 2'b11, 16'hC3A5);
    rd_chk(AWIN, 2'b11, 16'h0000, "R3 code 3 reads zero");
    rd_chk(AWIN, 2'b11, 16'h1231, "R3 month/day alarm");
    rd_chk(AWIN, 2'b11, 16'h0623, "R3 weekday/hours alarm");
    rd_chk(AWIN, 2'b11, 16'h5959, "R3 minutes/seconds alarm");
    rd_chk(ACFG, 2'b11, 16'hC0A5, "R4 alarm pointer after reads");
    wr_reg(ACFG, 2'b11, 16'hC1A5);
    rd_chk(AWIN, 2'b01, 16'h0623, "R4 lower-byte read");
    rd_chk(ACFG, 2'b11, 16'hC0A5, "R4 lower-byte read decrements");

    // R10 general reset
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    rd_chk(ACFG, 2'b11, 16'h0000, "R10 alarm config cleared");
    rd_chk(CFG,  2'b11, 16'h8200, "R10 config kept");
    rd_chk(TWIN, 2'b11, 16'h1F3F, "R10 time field kept");
    rd_chk(AWIN, 2'b11, 16'h5959, "R10 alarm field kept");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule